// File: doc/BRIEF.md
# Seconds Real-Time Counter

This block keeps wall-clock seconds as a 32-bit up-counter. A free-running 32.768 kHz clock enters on a single pin. It is brought into the system clock domain, and its rising edges are counted by a binary prescaler. The prescaler produces one increment enable per 2^PRESCALE_W slow edges, which is once per second at the default width of 15. Software-facing logic outside this block drives plain control pins. Those pins start and stop counting, preset the count, set a compare value, and clear the alarm.

When the count becomes equal to the compare value, a sticky raw alarm flag is set and the counter keeps running. The flag is gated by a mask to form the interrupt line. A one-cycle trigger pulse is also issued for a DMA engine when that trigger is enabled. A second count output, the snapshot, always carries the same value as the live count.

Every pin is a plain control or status level. There is no streaming data path, so the block has no valid/ready handshake and never applies back-pressure.

Top module: `rtc_seconds_counter`

## Requirements
- R1: While `run_en` is high, the count rises by exactly one for every 2^PRESCALE_W rising edges seen on `slow_clk_in`, and by no other amount.
- R2: After reset the count and the snapshot are 1, and `raw_flag`, `irq_o` and `dma_trig` are 0.
- R3: A cycle with `load_we` high puts `load_val` into the count at that clock edge. It also discards the partial prescaler progress, so the next increment needs a full 2^PRESCALE_W slow edges.
- R4: An increment from 0xFFFFFFFF gives 0x00000000, and counting continues upward from there.
- R5: `snap_out` equals `count_out` in every cycle.
- R6: While `run_en` is low, the count holds and the prescaler is cleared. Partial progress made before a pause is therefore lost.
- R7: On the clock edge after the count becomes equal to `match_val`, `raw_flag` goes to 1, whether the count got there by increment or by load. The flag stays at 1 until it is cleared, and counting continues past the match.
- R8: `irq_o` is 1 exactly when `raw_flag` is 1 and `irq_mask` is 1.
- R9: `irq_clr` high at a clock edge drops `raw_flag` (and so `irq_o`) to 0. If a new match event lands on the same edge, the flag stays at 1.
- R10: `dma_trig` is high for exactly one cycle, on the edge where a match event sets the flag, and only when `dma_en` is 1.
- R11: `slow_clk_in` passes through two synchroniser flip-flops and an edge detector. A slow rising edge that completes the prescaler changes the count on the third system clock edge after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_in | input | 1 | 32.768 kHz reference, asynchronous to clk |
| run_en | input | 1 | Count enable; low pauses and clears the prescaler |
| load_val | input | CNT_W | Preset value for the count |
| load_we | input | 1 | Load strobe, one cycle per load |
| match_val | input | CNT_W | Alarm compare value |
| irq_mask | input | 1 | Lets the raw flag reach `irq_o` |
| dma_en | input | 1 | Enables the DMA trigger pulse |
| irq_clr | input | 1 | Clear for the alarm flag |
| count_out | output | CNT_W | Live seconds count |
| snap_out | output | CNT_W | Snapshot register, always equal to the count |
| raw_flag | output | 1 | Sticky unmasked alarm flag |
| irq_o | output | 1 | Masked alarm interrupt |
| dma_trig | output | 1 | Single-cycle DMA trigger on a match |

## Verification
Each result is due at a fixed number of cycles after its stimulus:

- **Slow edge to count:** a slow rising edge that completes the prescaler moves the count three system edges later.
- **Load:** a load moves the count on the very edge that samples it.
- **Alarm:** the flag and the DMA pulse appear one edge after the count becomes equal to the compare value.

The bench drives inputs on falling edges and samples outputs on falling edges, once those latencies have elapsed. For the synchroniser latency it samples at both the second and the third edge after a slow rise. DMA pulses are counted by a monitor on every rising edge, so a pulse one cycle wide cannot be missed or counted twice.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DEF_CNT_W   = 32;
  localparam int unsigned DEF_PRE_W   = 15;
  localparam int unsigned DEF_SYNC_N  = 2;
  localparam int unsigned START_VALUE = 1;
endpackage

// File: rtl/rtc_sync_edge.sv
module rtc_sync_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // SYNC_N synchroniser stages plus one history stage for the edge detector.
  logic [SYNC_N:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_N-1:0], async_in};
  end

  assign rise = pipe_q[SYNC_N-1] & ~pipe_q[SYNC_N];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic restart,
  input  logic rise,
  output logic tick
);
  localparam logic [PRE_W-1:0] LAST = '1;

  logic [PRE_W-1:0] pre_q;

  // A tick is the slow edge that completes the count, while running and not restarting.
  assign tick = run_en & rise & ~restart & (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (!run_en || restart) pre_q <= '0;
    else if (rise)              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] snap_q
);
  localparam logic [CNT_W-1:0] START = CNT_W'(rtc_pkg::START_VALUE);

  logic [CNT_W-1:0] count_d;
  logic             upd;

  always_comb begin
    upd     = load_we | tick;
    count_d = load_we ? load_val : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= START;
      snap_q  <= START;
    end else if (upd) begin
      count_q <= count_d;
      snap_q  <= count_d;
    end
  end
endmodule

// File: rtl/rtc_match_flag.sv
module rtc_match_flag #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] match_val,
  input  logic             irq_clr,
  input  logic             irq_mask,
  input  logic             dma_en,
  output logic             raw_flag,
  output logic             irq_o,
  output logic             dma_trig
);
  logic eq, eq_q, hit;

  assign eq  = (count == match_val);
  assign hit = eq & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q     <= 1'b0;
      raw_flag <= 1'b0;
      dma_trig <= 1'b0;
    end else begin
      eq_q     <= eq;
      raw_flag <= hit | (raw_flag & ~irq_clr);
      dma_trig <= hit & dma_en;
    end
  end

  assign irq_o = raw_flag & irq_mask;
endmodule

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter #(
  parameter int unsigned CNT_W  = rtc_pkg::DEF_CNT_W,
  parameter int unsigned PRE_W  = rtc_pkg::DEF_PRE_W,
  parameter int unsigned SYNC_N = rtc_pkg::DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk_in,
  input  logic             run_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_we,
  input  logic [CNT_W-1:0] match_val,
  input  logic             irq_mask,
  input  logic             dma_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_out,
  output logic [CNT_W-1:0] snap_out,
  output logic             raw_flag,
  output logic             irq_o,
  output logic             dma_trig
);
  logic slow_rise;
  logic sec_tick;

  rtc_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (slow_clk_in),
    .rise     (slow_rise)
  );

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .restart (load_we),
    .rise    (slow_rise),
    .tick    (sec_tick)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .load_we  (load_we),
    .load_val (load_val),
    .count_q  (count_out),
    .snap_q   (snap_out)
  );

  rtc_match_flag #(.CNT_W(CNT_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count_out),
    .match_val (match_val),
    .irq_clr   (irq_clr),
    .irq_mask  (irq_mask),
    .dma_en    (dma_en),
    .raw_flag  (raw_flag),
    .irq_o     (irq_o),
    .dma_trig  (dma_trig)
  );
endmodule

// File: rtl/rtc_seconds_counter_chk.sv
module rtc_seconds_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             load_we,
  input logic [CNT_W-1:0] load_val,
  input logic             irq_mask,
  input logic             dma_en,
  input logic [CNT_W-1:0] count_out,
  input logic [CNT_W-1:0] snap_out,
  input logic             raw_flag,
  input logic             irq_o,
  input logic             dma_trig
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_we) && count_out != $past(count_out)) |-> count_out == $past(count_out) + 1'b1);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> count_out == $past(load_val));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_we) && $past(count_out) == ALL1 && count_out != ALL1) |-> count_out == '0);

  assert_snap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_out == count_out);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_we) |=> $stable(count_out));

  assert_irq_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_flag && irq_mask));

  assert_dma_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_trig |=> !dma_trig);

  assert_dma_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_trig |-> (raw_flag && $past(dma_en)));
endmodule

bind rtc_seconds_counter rtc_seconds_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .load_we   (load_we),
  .load_val  (load_val),
  .irq_mask  (irq_mask),
  .dma_en    (dma_en),
  .count_out (count_out),
  .snap_out  (snap_out),
  .raw_flag  (raw_flag),
  .irq_o     (irq_o),
  .dma_trig  (dma_trig)
);

// File: tb/test_rtc_seconds_counter.sv
module test_rtc_seconds_counter;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W      = 3;
  localparam int DIV        = 1 << PRE_W;

  typedef struct packed {
    logic [31:0] ld;
    logic [31:0] mt;
    logic [7:0]  nt;
    logic [31:0] ec;
    logic        ef;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 32'h0000_0012, 8'd3, 32'h0000_0013, 1'b1},
    '{32'h0000_0100, 32'h0000_0200, 8'd2, 32'h0000_0102, 1'b0},
    '{32'hFFFF_FFFE, 32'h0000_0000, 8'd3, 32'h0000_0001, 1'b1},
    '{32'h7FFF_FFFF, 32'h8000_0000, 8'd1, 32'h8000_0000, 1'b1},
    '{32'h0000_0000, 32'h0000_0005, 8'd0, 32'h0000_0000, 1'b0}
  };

  logic clk = 0, rst_n = 0, slow = 0, run_en = 0, load_we = 0;
  logic irq_mask = 0, dma_en = 0, irq_clr = 0;
  logic [31:0] load_val = '0, match_val = 32'hFFFF_FFFF;
  logic [31:0] count_out, snap_out;
  logic raw_flag, irq_o, dma_trig;
  int total = 0, bad = 0, dma_cnt = 0, base = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (dma_trig) dma_cnt++;

  rtc_seconds_counter #(.PRE_W(PRE_W)) i_rtc_seconds_counter (
    .clk(clk), .rst_n(rst_n), .slow_clk_in(slow), .run_en(run_en),
    .load_val(load_val), .load_we(load_we), .match_val(match_val),
    .irq_mask(irq_mask), .dma_en(dma_en), .irq_clr(irq_clr),
    .count_out(count_out), .snap_out(snap_out), .raw_flag(raw_flag),
    .irq_o(irq_o), .dma_trig(dma_trig)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic slow_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow = 1;
      repeat (4) @(negedge clk);
      slow = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic do_load(input logic [31:0] v);
    @(negedge clk) load_we = 1; load_val = v;
    @(negedge clk) load_we = 0;
  endtask

  task automatic do_clear;
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state, R5 snapshot
    chk("R2 count", count_out, 32'd1);
    chk("R5 snap", snap_out, 32'd1);
    chk("R2 raw", {31'd0, raw_flag}, 32'd0);
    chk("R2 irq", {31'd0, irq_o}, 32'd0);
    chk("R2 dma", dma_cnt, 0);

    run_en = 1; irq_mask = 1; dma_en = 1;
    // vector table: R1 R4 R7 R10
    for (int v = 0; v < NV; v++) begin
      @(negedge clk) match_val = VECS[v].mt;
      do_load(VECS[v].ld);
      @(negedge clk);
      do_clear();
      base = dma_cnt;
      slow_pulse(int'(VECS[v].nt) * DIV);
      repeat (3) @(negedge clk);
      chk($sformatf("R1 R4 vec%0d count", v), count_out, VECS[v].ec);
      chk($sformatf("R5 vec%0d snap", v), snap_out, VECS[v].ec);
      chk($sformatf("R7 vec%0d raw", v), {31'd0, raw_flag}, {31'd0, VECS[v].ef});
      chk($sformatf("R8 vec%0d irq", v), {31'd0, irq_o}, {31'd0, VECS[v].ef});
      chk($sformatf("R10 vec%0d dma", v), dma_cnt - base, {31'd0, VECS[v].ef});
    end

    // R11 synchroniser latency
    do_load(32'h40);
    slow_pulse(DIV - 1);
    @(negedge clk) slow = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 edge2", count_out, 32'h40);
    @(negedge clk);
    chk("R11 edge3", count_out, 32'h41);
    repeat (3) @(negedge clk);
    slow = 0;
    repeat (4) @(negedge clk);

    // R3 load restarts prescaler
    slow_pulse(DIV / 2);
    do_load(32'h500);
    slow_pulse(DIV / 2);
    chk("R3 restart", count_out, 32'h500);
    slow_pulse(DIV / 2);
    chk("R3 full period", count_out, 32'h501);

    // R6 pause holds count and clears prescaler
    @(negedge clk) run_en = 0;
    slow_pulse(2 * DIV);
    chk("R6 hold", count_out, 32'h501);
    @(negedge clk) run_en = 1;
    slow_pulse(DIV / 2);
    @(negedge clk) run_en = 0;
    @(negedge clk) run_en = 1;
    slow_pulse(DIV / 2);
    chk("R6 discard", count_out, 32'h501);
    slow_pulse(DIV / 2);
    chk("R6 resume", count_out, 32'h502);

    // R8 mask
    @(negedge clk) irq_mask = 0; match_val = 32'h503;
    do_clear();
    slow_pulse(DIV);
    repeat (2) @(negedge clk);
    chk("R8 raw set", {31'd0, raw_flag}, 32'd1);
    chk("R8 masked", {31'd0, irq_o}, 32'd0);
    @(negedge clk) irq_mask = 1;
    @(negedge clk);
    chk("R8 unmasked", {31'd0, irq_o}, 32'd1);

    // R9 clear, and clear coinciding with a match
    do_clear();
    chk("R9 clear raw", {31'd0, raw_flag}, 32'd0);
    chk("R9 clear irq", {31'd0, irq_o}, 32'd0);
    @(negedge clk) match_val = 32'h600;
    do_load(32'h600);
    @(negedge clk);
    chk("R7 load match", {31'd0, raw_flag}, 32'd1);
    @(negedge clk) match_val = 32'h700;
    @(negedge clk) load_we = 1; load_val = 32'h700;
    @(negedge clk) load_we = 0; irq_clr = 1;
    @(negedge clk) irq_clr = 0;
    chk("R9 set wins", {31'd0, raw_flag}, 32'd1);
    do_clear();
    chk("R9 later clear", {31'd0, raw_flag}, 32'd0);

    // R10 DMA disabled
    @(negedge clk) dma_en = 0; match_val = 32'h800;
    base = dma_cnt;
    do_load(32'h800);
    repeat (3) @(negedge clk);
    chk("R10 no dma", dma_cnt - base, 0);
    chk("R7 raw no dma", {31'd0, raw_flag}, 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule